// File: doc/BRIEF.md
# BERT Test Pattern Generator

This block makes a serial bit-error-rate test stream, one bit per enabled clock, and can put that stream into a transmit data path in place of the normal data. It has three families of pattern. The first is a pseudorandom sequence from one of five maximal-length shift registers. The second is a programmable word of 17 to 32 bits that repeats. The third is two 16-bit half-words, each sent a programmable number of times before the generator switches to the other half.

Host software programs the selection, length, count and pattern word on static inputs. It then makes the generator take them with a 0-to-1 transition on a load bit. A payload-valid input gates the clock enable, so framing logic outside the block can hold the pattern still during overhead bits and insert it into payload positions only. A select bit chooses between the generated bit and the incoming data. An invert bit complements whichever of the two is sent.

Top module: `bert_patgen`

## Requirements
- R1: A reload happens only on a clock edge where `load_req` is 1 and was 0 at the previous edge. Keeping `load_req` at 1 has no further effect. A reload restarts the chosen pattern at its first bit, and it takes priority over advancing in that cycle.
- R2: Code values for `pat_sel`: 0, 1, 2, 3 and 4 give pseudorandom orders 7, 11, 15, 20 and 23. Code 5 gives the repeating word. Codes 6 and 7 give alternating words. `pat_sel`, `rep_len`, `alt_cnt` and `pat_word` are captured only at a reload edge, and later changes to them have no effect until the next reload.
- R3: A pseudorandom pattern of order N with tap T is a Fibonacci shift register that starts all ones at reload. The tap pairs are (7,6), (11,9), (15,14), (20,17) and (23,18). Its first N bits are ones, and bit j for j ≥ N equals bit j−N XOR bit j−T. The live register is never all zeros.
- R4: The repeating word sends `pat_word` bits 0, 1, 2 and so on up to bit `rep_len`+16, then wraps back to bit 0.
- R5: The alternating pattern sends bits 0..15 of `pat_word`, lowest first, `alt_cnt`+1 times. It then sends bits 16..31 `alt_cnt`+1 times, and the cycle repeats.
- R6: The pattern advances by one bit only on cycles where `ce` and `pay_vld` are both 1. On any other cycle the position holds.
- R7: When `gen_en` is 0, `data_out` carries `data_in`. When it is 1, `data_out` carries the current pattern bit.
- R8: When `tx_inv` is 1, the selected bit is inverted before it reaches `data_out`. When it is 0, the selected bit passes unchanged.
- R9: `data_out` is registered. After a clock edge it shows the selection, inversion and pattern bit that applied at that edge.
- R10: While `rst_n` is low, `data_out` is 0. Leaving reset, the block behaves as if code 0 had been loaded with all other fields zero, and the last `load_req` value it has seen is taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Bit-rate clock enable |
| pay_vld | input | 1 | Payload position qualifier; pattern advances only when 1 together with ce |
| load_req | input | 1 | Host load bit; a rising edge reloads the generator |
| pat_sel | input | 3 | Pattern family and order selection |
| rep_len | input | 4 | Repeating-word length minus 17 |
| alt_cnt | input | 8 | Alternating-word repeat count minus 1 |
| pat_word | input | 32 | Programmable pattern word |
| gen_en | input | 1 | 1: send the pattern; 0: send data_in |
| tx_inv | input | 1 | Invert the outgoing bit |
| data_in | input | 1 | Normal transmit data |
| data_out | output | 1 | Registered transmit bit |

## Verification
The hardest situation to reach is a second reload that arrives while the generator is running with configuration values that have already been captured. Reaching it needs a falling and then a rising edge of `load_req`, while the configuration inputs carry values unrelated to the pattern in use. The stimulus changes every configuration input on every cycle. It holds `load_req` high for long stretches and occasionally drops it for one cycle, so that a reload picks up whatever random configuration is present at that moment. The bench models that capture itself. Directed runs cover the shortest and longest repeating words, and an alternating count of 255 run long enough to see the half-word swap.

// File: rtl/bert_pkg.sv
package bert_pkg;

  typedef enum logic [2:0] {
    SEL_P7   = 3'd0,
    SEL_P11  = 3'd1,
    SEL_P15  = 3'd2,
    SEL_P20  = 3'd3,
    SEL_P23  = 3'd4,
    SEL_REP  = 3'd5,
    SEL_ALT  = 3'd6,
    SEL_ALT2 = 3'd7
  } pat_sel_e;

  function automatic logic sel_is_prbs(input logic [2:0] s);
    return (s <= SEL_P23);
  endfunction

  function automatic logic sel_is_alt(input logic [2:0] s);
    return (s >= SEL_ALT);
  endfunction

  // register order (length) of the pseudorandom shift register
  function automatic int unsigned prbs_order(input logic [2:0] s);
    case (s)
      SEL_P11: return 11;
      SEL_P15: return 15;
      SEL_P20: return 20;
      SEL_P23: return 23;
      default: return 7;
    endcase
  endfunction

  // second feedback tap position (1-based)
  function automatic int unsigned prbs_tap(input logic [2:0] s);
    case (s)
      SEL_P11: return 9;
      SEL_P15: return 14;
      SEL_P20: return 17;
      SEL_P23: return 18;
      default: return 6;
    endcase
  endfunction

  // repeating-word period from the length field
  function automatic int unsigned rep_period(input int unsigned len_field,
                                             input int unsigned base);
    return len_field + base;
  endfunction

endpackage

// File: rtl/bert_load_edge.sv
module bert_load_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic load_lvl,
  output logic load_pulse
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= load_lvl;
  end

  assign load_pulse = load_lvl & ~lvl_q;

  // R1: a held-high level yields a single reload pulse
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse);

endmodule

// File: rtl/bert_prbs_gen.sv
module bert_prbs_gen
  import bert_pkg::*;
#(
  parameter int unsigned MAX_ORD = 23
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       adv,
  input  logic [2:0] sel,
  output logic       bit_o
);
  localparam int unsigned SW = $clog2(MAX_ORD);

  logic [MAX_ORD-1:0] sr;
  logic [SW-1:0]      msb_i;
  logic [SW-1:0]      tap_i;
  logic [MAX_ORD-1:0] live_mask;
  logic               fb;

  always_comb begin
    msb_i     = SW'(prbs_order(sel) - 1);
    tap_i     = SW'(prbs_tap(sel) - 1);
    live_mask = MAX_ORD'((64'd1 << prbs_order(sel)) - 64'd1);
    fb        = sr[msb_i] ^ sr[tap_i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   sr <= '1;
    else if (load) sr <= '1;
    else if (adv)  sr <= {sr[MAX_ORD-2:0], fb};
  end

  assign bit_o = sr[msb_i];

  // R3: reload seeds all ones
  p_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sr == '1));
  // R3: the live register never locks up at zero
  p_no_lockup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sr & live_mask) != '0);
  // R6: no advance, no change
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(sr));

endmodule

// File: rtl/bert_word_seq.sv
module bert_word_seq
  import bert_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              alt_mode,
  input  logic [LEN_W-1:0]  len_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [WORD_W-1:0] word_q,
  output logic              bit_o
);
  localparam int unsigned IDX_W    = $clog2(WORD_W);
  localparam int unsigned HALF     = WORD_W / 2;
  localparam int unsigned HIDX_W   = $clog2(HALF);
  localparam int unsigned REP_BASE = WORD_W - (1 << LEN_W) + 1;

  logic [IDX_W-1:0]  idx;
  logic [HIDX_W-1:0] sub;
  logic              half;
  logic [CNT_W-1:0]  rcnt;
  logic [IDX_W:0]    period;
  logic              rep_wrap;
  logic              alt_half_end;
  logic              alt_swap;
  logic [IDX_W-1:0]  alt_pos;

  always_comb begin
    period       = (IDX_W+1)'(rep_period(int'(len_q), REP_BASE));
    rep_wrap     = ({1'b0, idx} == period - 1'b1);
    alt_half_end = (sub == HIDX_W'(HALF - 1));
    alt_swap     = alt_half_end && (rcnt == cnt_q);
    alt_pos      = IDX_W'({half, sub});
  end

  // repeating-word position
  always_ff @(posedge clk) begin
    if (!rst_n || load) idx <= '0;
    else if (adv)       idx <= rep_wrap ? '0 : idx + 1'b1;
  end

  // alternating-word position, repeat count and half select
  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      sub  <= '0;
      half <= 1'b0;
      rcnt <= '0;
    end else if (adv) begin
      sub <= sub + 1'b1;
      if (alt_half_end) begin
        if (alt_swap) begin
          rcnt <= '0;
          half <= ~half;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end

  assign bit_o = alt_mode ? word_q[alt_pos] : word_q[idx];

  // R4: repeating position stays inside the programmed period
  p_rep_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, idx} < period);
  // R5: repeat counter never passes the programmed count
  p_alt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= cnt_q);
  // R5: the half-word only flips at the end of the last repeat
  p_alt_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(adv && alt_swap)) |=> $stable(half));
  // R6: positions hold when not advancing
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable({idx, sub, rcnt}));

endmodule

// File: rtl/bert_patgen.sv
module bert_patgen
  import bert_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned MAX_ORD = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              pay_vld,
  input  logic              load_req,
  input  logic [2:0]        pat_sel,
  input  logic [LEN_W-1:0]  rep_len,
  input  logic [CNT_W-1:0]  alt_cnt,
  input  logic [WORD_W-1:0] pat_word,
  input  logic              gen_en,
  input  logic              tx_inv,
  input  logic              data_in,
  output logic              data_out
);
  logic              load_pulse;
  logic              adv;
  logic [2:0]        sel_q;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word_q;
  logic              prbs_bit;
  logic              word_bit;
  logic              gen_bit;
  logic              sel_bit;

  bert_load_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_lvl   (load_req),
    .load_pulse (load_pulse)
  );

  assign adv = ce & pay_vld;

  // configuration captured only at the reload edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= SEL_P7;
      len_q  <= '0;
      cnt_q  <= '0;
      word_q <= '0;
    end else if (load_pulse) begin
      sel_q  <= pat_sel;
      len_q  <= rep_len;
      cnt_q  <= alt_cnt;
      word_q <= pat_word;
    end
  end

  bert_prbs_gen #(.MAX_ORD(MAX_ORD)) u_prbs (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_pulse),
    .adv   (adv),
    .sel   (sel_q),
    .bit_o (prbs_bit)
  );

  bert_word_seq #(.WORD_W(WORD_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_pulse),
    .adv      (adv),
    .alt_mode (sel_is_alt(sel_q)),
    .len_q    (len_q),
    .cnt_q    (cnt_q),
    .word_q   (word_q),
    .bit_o    (word_bit)
  );

  always_comb begin
    gen_bit = sel_is_prbs(sel_q) ? prbs_bit : word_bit;
    sel_bit = gen_en ? gen_bit : data_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) data_out <= 1'b0;
    else        data_out <= sel_bit ^ tx_inv;
  end

  // R2: captured configuration is frozen between reload edges
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |=> $stable({sel_q, len_q, cnt_q, word_q}));
  // R7: bypass sends the incoming data one cycle later
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !tx_inv) |=> (data_out == $past(data_in)));
  // R8: inverted bypass sends the complement
  p_bypass_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && tx_inv) |=> (data_out != $past(data_in)));

endmodule

// File: tb/bert_patgen_tb.sv
module bert_patgen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, pay_vld = 1'b0, load_req = 1'b0;
  logic [2:0]  pat_sel = 3'd0;
  logic [3:0]  rep_len = 4'd0;
  logic [7:0]  alt_cnt = 8'd0;
  logic [31:0] pat_word = 32'd0;
  logic        gen_en = 1'b0, tx_inv = 1'b0, data_in = 1'b0;
  logic        data_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state
  int          m_sel = 0, m_rl = 0, m_ac = 0;
  logic [31:0] m_w = 32'd0;
  bit          hist [0:8191];
  int          k = 0;
  logic        prev_ld = 1'b0;

  always #2ns clk = ~clk;

  bert_patgen u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .pay_vld(pay_vld), .load_req(load_req),
    .pat_sel(pat_sel), .rep_len(rep_len), .alt_cnt(alt_cnt), .pat_word(pat_word),
    .gen_en(gen_en), .tx_inv(tx_inv), .data_in(data_in), .data_out(data_out)
  );

  function automatic int ord_of(input int s);
    int t [5] = '{7, 11, 15, 20, 23};
    return t[s];
  endfunction
  function automatic int tap_of(input int s);
    int t [5] = '{6, 9, 14, 17, 18};
    return t[s];
  endfunction

  // R3: recurrence form of the sequence
  task automatic fill_hist(input int s);
    int n = ord_of(s);
    int t = tap_of(s);
    for (int j = 0; j < 8192; j++)
      hist[j] = (j < n) ? 1'b1 : (hist[j-n] ^ hist[j-t]);
  endtask

  function automatic bit model_bit(input int kk);
    int p, h;
    if (m_sel <= 4) return (kk < 8192) ? hist[kk] : 1'b0;
    if (m_sel == 5) begin
      p = m_rl + 17;                       // R4
      return m_w[kk % p];
    end
    h = (kk / (16 * (m_ac + 1))) % 2;      // R5
    return m_w[h*16 + kk % 16];
  endfunction

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: data_out=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, check at next negedge (R9)
  task automatic step(input logic c, input logic p, input logic ge,
                      input logic iv, input logic di, input logic ld);
    logic  e;
    string tag;
    ce = c; pay_vld = p; gen_en = ge; tx_inv = iv; data_in = di; load_req = ld;
    @(posedge clk);
    e = (ge ? model_bit(k) : di) ^ iv;
    if (!ge)            tag = "R7 R9";
    else if (iv)        tag = "R8 R9";
    else if (m_sel <= 4) tag = "R3 R6";
    else if (m_sel == 5) tag = "R4 R6";
    else                 tag = "R5 R6";
    if (ld && !prev_ld) begin            // R1 reload, R2 capture
      m_sel = int'(pat_sel); m_rl = int'(rep_len); m_ac = int'(alt_cnt); m_w = pat_word;
      if (m_sel <= 4) fill_hist(m_sel);
      k = 0;
    end else if (c && p) begin
      k++;
    end
    prev_ld = ld;
    @(negedge clk);
    check(data_out === e, tag, data_out, e);
  endtask

  task automatic set_cfg(input int s, input int rl, input int ac, input logic [31:0] w);
    pat_sel = 3'(s); rep_len = 4'(rl); alt_cnt = 8'(ac); pat_word = w;
  endtask

  // reload with config, then scramble config inputs (R2: ignored)
  task automatic directed(input int s, input int rl, input int ac,
                          input logic [31:0] w, input int len);
    set_cfg(s, rl, ac, w);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < len; i++) begin
      set_cfg(int'($urandom % 8), int'($urandom % 16), int'($urandom % 256), $urandom);
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'(($urandom)), 1'b1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    fill_hist(0);
    // R10: output low during reset
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      check(data_out === 1'b0, "R10", data_out, 1'b0);
    end
    rst_n = 1'b1;
    // R10: default pattern is order 7 from the all-ones seed, no load yet
    for (int i = 0; i < 150; i++)
      step(1'b1, 1'(($urandom % 4) != 0), 1'b1, 1'b0, 1'b0, 1'b0);

    // directed corners: shortest/longest repeat (R4), each order (R3), alt counts (R5)
    directed(5, 0, 0, 32'hA5C3_0F96, 80);
    directed(5, 15, 0, 32'h8000_0001, 100);
    for (int s = 0; s < 5; s++) directed(s, 0, 0, 32'd0, 400);
    directed(6, 0, 0, 32'h1234_ABCD, 100);
    directed(7, 2, 3, 32'hF0F0_0FF1, 300);
    directed(6, 0, 255, 32'h0001_FFFE, 4200);

    // R1: reload mid-run with the same setup restarts at bit 0
    directed(5, 3, 0, 32'h0000_00FF, 13);
    directed(5, 3, 0, 32'h0000_00FF, 40);

    // R6 holds when payload qualifier is low: advance with stalls
    set_cfg(2, 0, 0, 32'd0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 200; i++)
      step(1'($urandom), 1'($urandom), 1'b1, 1'b0, 1'b0, 1'b1);

    // constrained random segments
    for (int seg = 0; seg < 30; seg++) begin
      int   len;
      logic iv;
      len = 100 + int'($urandom % 1400);
      iv  = 1'($urandom);
      set_cfg(int'($urandom % 8), int'($urandom % 16),
              (($urandom % 4) == 0) ? int'($urandom % 256) : int'($urandom % 4), $urandom);
      step(1'b0, 1'b0, 1'b1, iv, 1'b0, 1'b0);
      step(1'b1, 1'b1, 1'b1, iv, 1'b0, 1'b1);
      for (int i = 0; i < len; i++) begin
        logic ld;
        ld = (($urandom % 200) != 0);       // R1: mostly held high, rare re-arm
        set_cfg(int'($urandom % 8), int'($urandom % 16), int'($urandom % 8), $urandom);
        if (($urandom % 50) == 0) iv = ~iv;  // R8
        step(1'(($urandom % 4) != 0), 1'(($urandom % 5) != 0),
             1'(($urandom % 10) != 0), iv, 1'($urandom), ld);
      end
    end

    summary();
    $finish;
  end
endmodule